// File: doc/BRIEF.md
# EDO DRAM Cycle Classifier and Refresh Row Source

This block sits on the device side of a behavioural EDO DRAM model. It watches the row strobe, the two column strobes, the write strobe and the output-enable strobe (all active low), all sampled on a fast simulation clock. From the order in which the strobe edges arrive it works out which kind of memory cycle the controller is running. The kinds are a plain read, an early write, a read-modify-write, a row-only refresh, a column-before-row refresh, and a hidden refresh.

Each time the row strobe falls, the block reports which row the array model must open. That row is the address pins for ordinary activations and an internal 10-bit wrapping counter for the two counter-driven refresh kinds. The block also drives the enable for the data output driver. The array model uses the reported cycle kind, the row and the enable to store, refresh and drive data. The array itself and any analog timing checks live elsewhere.

Every strobe passes through one sampling register. Each report therefore appears two clock edges after the input change that caused it.

Top module: `edo_cycle_decoder`

## Requirements
- R1: When the row strobe falls while either column strobe is low, and no access is being held from the previous cycle, the block reports kind 5 (counter refresh). The reported row is the refresh counter's value, and the counter then advances by one.
- R2: A row strobe low period in which both column strobes stay high is reported as kind 4 (row-only refresh) when the row strobe rises. The row reported at the falling edge is the address-pin value, and the output enable stays 0.
- R3: When the column strobe is held low after an access and the row strobe goes high and then low again, the second falling edge is reported as kind 6 (hidden refresh). That report uses the counter row and advances the counter, and the output enable stays 1 throughout.
- R4: When the write strobe is low at the first column strobe fall, the cycle is reported as kind 2 (early write) at the row strobe rise. The output enable stays 0 even with the output-enable strobe low.
- R5: When the write strobe falls after a read access while a column strobe is low, the cycle is reported as kind 3 (read-modify-write). The output enable is 1 before the write strobe falls and 0 from then on.
- R6: A cycle with an access and the write strobe high throughout is reported as kind 1 (read). The output enable is 1 only while output-enable is low, a column strobe is low and a read access is armed. It drops when output-enable goes high or when the row strobe and both column strobes are high.
- R7: The refresh counter is 0 after reset and wraps from 1023 to 0.
- R8: Kinds 5 and 6 are strobed at the row strobe fall; kinds 1 to 4 are strobed at the row strobe rise; the rise that ends a refresh cycle gives no strobe. The type strobe and the row strobe last one clock and appear two clock edges after the input change.
- R9: After reset, both strobes, the type output and the output enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper column strobe, active low |
| lcas_n | input | 1 | Lower column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| row_addr | input | ROW_W | Row address pins |
| cyc_type | output | 3 | Last reported cycle kind (1 read, 2 early write, 3 read-modify-write, 4 row-only, 5 counter refresh, 6 hidden) |
| cyc_stb | output | 1 | One-clock pulse when cyc_type is updated |
| row_out | output | ROW_W | Row to open or refresh |
| row_stb | output | 1 | One-clock pulse at each row strobe fall |
| dout_en | output | 1 | Data output driver enable |

## Verification
Some properties are checked by assertions on every clock:
- The output enable is never 1 unless output-enable and a column strobe were both low in the sample before.
- A row-only refresh report never coincides with an active output enable.
- Every counter-refresh report comes with a row strobe.
- The counter either steps by exactly one with wrap or holds still.

Other behaviour only the bench scenarios can show: that each strobe ordering yields the right kind and row, and that the counter rows form the expected sequence across a wrap and a reset. The same applies to the output enable switching at the points where output-enable rises and where the write strobe falls late.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    CYC_NONE    = 3'd0,
    CYC_READ    = 3'd1,
    CYC_EWRITE  = 3'd2,
    CYC_RMW     = 3'd3,
    CYC_RASONLY = 3'd4,
    CYC_CBR     = 3'd5,
    CYC_HIDDEN  = 3'd6
  } cyc_e;

  localparam int NSTB    = 5;
  localparam int IX_RAS  = 0;
  localparam int IX_UCAS = 1;
  localparam int IX_LCAS = 2;
  localparam int IX_WE   = 3;
  localparam int IX_OE   = 4;
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] cur_n,
  output logic [N-1:0] fell,
  output logic [N-1:0] rose
);
  logic [N-1:0] prev_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_n  <= '1;
      prev_n <= '1;
    end else begin
      cur_n  <= raw_n;
      prev_n <= cur_n;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fell[i] = prev_n[i] & ~cur_n[i];
    assign rose[i] = ~prev_n[i] & cur_n[i];
  end
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (inc)
      cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
  end

  // R7: one step per request, wrapping at the top value
  a_r7_step_wrap: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt == (($past(cnt) == TOP) ? '0 : $past(cnt) + 1'b1)));
  // R1: the counter only moves on a refresh request
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
  import edo_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTB-1:0]  cur_n,
  input  logic [NSTB-1:0]  fell,
  input  logic [NSTB-1:0]  rose,
  input  logic [ROW_W-1:0] ctr,
  input  logic [ROW_W-1:0] row_addr,
  output logic [2:0]       cyc_type,
  output logic             cyc_stb,
  output logic [ROW_W-1:0] row_out,
  output logic             row_stb,
  output logic             ctr_inc,
  output logic             dout_en
);
  logic ras_lo, cas_lo, we_lo, oe_lo;
  logic cas_lo_q, cas_start, cas_end;
  logic ras_fall, ras_rise, access_ok, late_evt;
  logic ref_cyc, acc_hold, cas_seen, early, late, armed, armed_d;

  assign ras_lo    = ~cur_n[IX_RAS];
  assign cas_lo    = ~cur_n[IX_UCAS] | ~cur_n[IX_LCAS];
  assign we_lo     = ~cur_n[IX_WE];
  assign oe_lo     = ~cur_n[IX_OE];
  assign cas_start = cas_lo & ~cas_lo_q;
  assign cas_end   = ~cas_lo & cas_lo_q;
  assign ras_fall  = fell[IX_RAS];
  assign ras_rise  = rose[IX_RAS];
  assign access_ok = ras_lo & ~ref_cyc & ~ras_fall;
  assign late_evt  = access_ok & fell[IX_WE] & cas_lo & cas_seen & ~early;
  assign ctr_inc   = ras_fall & cas_lo;

  always_comb begin
    armed_d = armed;
    if (~ras_lo & ~cas_lo)
      armed_d = 1'b0;
    else if (access_ok & cas_start)
      armed_d = ~we_lo;
    else if (late_evt)
      armed_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_lo_q <= 1'b0;
      armed    <= 1'b0;
      dout_en  <= 1'b0;
      cyc_stb  <= 1'b0;
      row_stb  <= 1'b0;
      cyc_type <= CYC_NONE;
      row_out  <= '0;
      ref_cyc  <= 1'b0;
      acc_hold <= 1'b0;
      cas_seen <= 1'b0;
      early    <= 1'b0;
      late     <= 1'b0;
    end else begin
      cas_lo_q <= cas_lo;
      armed    <= armed_d;
      dout_en  <= armed_d & oe_lo & cas_lo;
      cyc_stb  <= 1'b0;
      row_stb  <= 1'b0;

      if (ras_fall) begin
        row_stb <= 1'b1;
        if (cas_lo) begin
          row_out  <= ctr;
          ref_cyc  <= 1'b1;
          cyc_stb  <= 1'b1;
          cyc_type <= acc_hold ? CYC_HIDDEN : CYC_CBR;
        end else begin
          row_out  <= row_addr;
          ref_cyc  <= 1'b0;
          cas_seen <= 1'b0;
          early    <= 1'b0;
          late     <= 1'b0;
        end
      end

      if (ras_rise) begin
        ref_cyc <= 1'b0;
        if (!ref_cyc) begin
          cyc_stb <= 1'b1;
          if (!cas_seen)  cyc_type <= CYC_RASONLY;
          else if (early) cyc_type <= CYC_EWRITE;
          else if (late)  cyc_type <= CYC_RMW;
          else            cyc_type <= CYC_READ;
        end
      end

      if (access_ok & cas_start & ~cas_seen) begin
        cas_seen <= 1'b1;
        early    <= we_lo;
      end
      if (late_evt)
        late <= 1'b1;

      if (cas_end)
        acc_hold <= 1'b0;
      else if (access_ok & cas_start)
        acc_hold <= 1'b1;
    end
  end

  // R6: driver only on after a sample with output-enable and a column strobe low
  a_r6_en_needs_oe_cas: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> ($past(cur_n[IX_OE]) == 1'b0 &&
                 ($past(cur_n[IX_UCAS]) == 1'b0 || $past(cur_n[IX_LCAS]) == 1'b0)));
  // R2: a row-only refresh never leaves the driver on
  a_r2_rasonly_quiet: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && cyc_type == CYC_RASONLY) |-> !dout_en);
  // R3: counter-based refresh reports always carry a row
  a_r3_refresh_has_row: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && (cyc_type == CYC_CBR || cyc_type == CYC_HIDDEN)) |-> row_stb);
  // R9: type strobe never names the idle code
  a_r9_stb_named: assert property (@(posedge clk) disable iff (rst)
    cyc_stb |-> cyc_type != CYC_NONE);
endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
  import edo_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             ucas_n,
  input  logic             lcas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] row_addr,
  output logic [2:0]       cyc_type,
  output logic             cyc_stb,
  output logic [ROW_W-1:0] row_out,
  output logic             row_stb,
  output logic             dout_en
);
  logic [NSTB-1:0]  raw_n, cur_n, fell, rose;
  logic [ROW_W-1:0] ctr;
  logic             ctr_inc;

  always_comb begin
    raw_n          = '1;
    raw_n[IX_RAS]  = ras_n;
    raw_n[IX_UCAS] = ucas_n;
    raw_n[IX_LCAS] = lcas_n;
    raw_n[IX_WE]   = we_n;
    raw_n[IX_OE]   = oe_n;
  end

  edo_strobe_sync #(.N(NSTB)) u_sync (
    .clk(clk), .rst(rst), .raw_n(raw_n),
    .cur_n(cur_n), .fell(fell), .rose(rose)
  );

  edo_refresh_ctr #(.W(ROW_W)) u_ctr (
    .clk(clk), .rst(rst), .inc(ctr_inc), .cnt(ctr)
  );

  edo_cycle_fsm #(.ROW_W(ROW_W)) u_fsm (
    .clk(clk), .rst(rst), .cur_n(cur_n), .fell(fell), .rose(rose),
    .ctr(ctr), .row_addr(row_addr),
    .cyc_type(cyc_type), .cyc_stb(cyc_stb),
    .row_out(row_out), .row_stb(row_stb),
    .ctr_inc(ctr_inc), .dout_en(dout_en)
  );
endmodule

// File: tb/tb_edo_cycle_decoder.sv
module tb_edo_cycle_decoder;
  localparam int RW = 10;
  localparam int NV = 9;
  // {kind, row, oe_n during access, expected enable mid-access}
  localparam logic [14:0] VEC [NV] = '{
    {3'd1, 10'h155, 1'b0, 1'b1},
    {3'd1, 10'h2AA, 1'b1, 1'b0},
    {3'd2, 10'h3FF, 1'b0, 1'b0},
    {3'd3, 10'h001, 1'b0, 1'b1},
    {3'd4, 10'h200, 1'b0, 1'b0},
    {3'd5, 10'h000, 1'b1, 1'b0},
    {3'd6, 10'h0F0, 1'b0, 1'b1},
    {3'd5, 10'h000, 1'b1, 1'b0},
    {3'd1, 10'h000, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [RW-1:0] row_addr = '0;
  logic [2:0]    cyc_type;
  logic          cyc_stb, row_stb, dout_en;
  logic [RW-1:0] row_out;

  int n_chk = 0, n_fail = 0, stb_cnt = 0, exp_ctr = 0;
  logic [2:0]    last_type = '0;
  logic [RW-1:0] last_row = '0;
  bit done = 0;

  edo_cycle_decoder #(.ROW_W(RW)) dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .row_addr(row_addr),
    .cyc_type(cyc_type), .cyc_stb(cyc_stb), .row_out(row_out),
    .row_stb(row_stb), .dout_en(dout_en)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (cyc_stb) begin
      stb_cnt   <= stb_cnt + 1;
      last_type <= cyc_type;
    end
    if (row_stb) last_row <= row_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd1: return "R6 read";
      3'd2: return "R4 early write";
      3'd3: return "R5 rmw";
      3'd4: return "R2 ras-only";
      3'd5: return "R1 cbr";
      default: return "R3 hidden";
    endcase
  endfunction

  task automatic run_cycle(input logic [2:0] kind, input logic [RW-1:0] row,
                           input bit oe, output bit en_mid);
    en_mid = 1'b0;
    row_addr = row;
    case (kind)
      3'd1: begin
        ras_n = 0; wt(3); oe_n = oe; ucas_n = 0; lcas_n = 0; wt(3);
        en_mid = dout_en; ucas_n = 1; lcas_n = 1; ras_n = 1; wt(3);
        oe_n = 1; wt(1);
      end
      3'd2: begin
        ras_n = 0; wt(3); we_n = 0; oe_n = oe; wt(1); ucas_n = 0; wt(3);
        en_mid = dout_en; ucas_n = 1; ras_n = 1; wt(3);
        we_n = 1; oe_n = 1; wt(1);
      end
      3'd3: begin
        ras_n = 0; wt(3); oe_n = oe; lcas_n = 0; wt(3);
        en_mid = dout_en; we_n = 0; wt(3);
        chk(dout_en == 1'b0, "R5 enable off after late write", dout_en, 0);
        lcas_n = 1; ras_n = 1; wt(3); we_n = 1; oe_n = 1; wt(1);
      end
      3'd4: begin
        ras_n = 0; wt(3); en_mid = dout_en; ras_n = 1; wt(3);
      end
      3'd5: begin
        ucas_n = 0; lcas_n = 0; wt(3); ras_n = 0; wt(3);
        en_mid = dout_en; ras_n = 1; wt(3); ucas_n = 1; lcas_n = 1; wt(3);
      end
      default: begin
        ras_n = 0; wt(3); oe_n = oe; ucas_n = 0; lcas_n = 0; wt(3);
        ras_n = 1; wt(3); ras_n = 0; wt(3);
        en_mid = dout_en; ras_n = 1; wt(3);
        ucas_n = 1; lcas_n = 1; oe_n = 1; wt(3);
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit en;
    int s0;
    logic [RW-1:0] erow;
    wt(4);
    chk(cyc_stb == 0 && row_stb == 0, "R9 strobes low in reset", cyc_stb, 0);
    chk(dout_en == 0, "R9 enable low in reset", dout_en, 0);
    chk(cyc_type == 0, "R9 type idle in reset", cyc_type, 0);
    rst = 0; wt(2);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] k;
      k = VEC[i][14:12];
      erow = (k == 3'd5 || k == 3'd6) ? RW'(exp_ctr) : VEC[i][11:2];
      s0 = stb_cnt;
      run_cycle(k, VEC[i][11:2], VEC[i][1], en);
      if (k == 3'd5 || k == 3'd6) exp_ctr = (exp_ctr + 1) % 1024;
      chk(last_type == k, tag_of(k), last_type, k);
      chk(stb_cnt - s0 == ((k == 3'd6) ? 2 : 1), "R8 strobe count", stb_cnt - s0,
          (k == 3'd6) ? 2 : 1);
      chk(last_row == erow, "R1 R2 row reported", last_row, erow);
      chk(en == VEC[i][0], tag_of(k), en, VEC[i][0]);
    end

    // R8: latency and single-clock width at a counter refresh
    ucas_n = 0; wt(3);
    s0 = stb_cnt;
    ras_n = 0;
    wt(1); chk(row_stb == 0, "R8 no strobe after one edge", row_stb, 0);
    wt(1); chk(row_stb == 1 && cyc_stb == 1, "R8 strobe after two edges", row_stb, 1);
    chk(cyc_type == 3'd5, "R1 type at fall", cyc_type, 5);
    chk(row_out == RW'(exp_ctr), "R1 counter row", row_out, exp_ctr);
    wt(1); chk(cyc_stb == 0 && row_stb == 0, "R8 one-clock strobe", cyc_stb, 0);
    exp_ctr = (exp_ctr + 1) % 1024;
    ras_n = 1; wt(3); ucas_n = 1; wt(3);
    chk(stb_cnt - s0 == 1, "R8 no strobe at refresh rise", stb_cnt - s0, 1);

    // R6: output-enable and strobe release turn the driver off
    ras_n = 0; wt(3); oe_n = 0; ucas_n = 0; wt(3);
    chk(dout_en == 1, "R6 enable on", dout_en, 1);
    oe_n = 1; wt(3);
    chk(dout_en == 0, "R6 off on output-enable high", dout_en, 0);
    oe_n = 0; wt(3);
    chk(dout_en == 1, "R6 back on", dout_en, 1);
    ucas_n = 1; ras_n = 1; wt(3);
    chk(dout_en == 0, "R6 off with all strobes high", dout_en, 0);
    chk(last_type == 3'd1, "R6 read type", last_type, 1);
    oe_n = 1; wt(1);

    // R7: wrap from 1023 to 0
    while (exp_ctr != 1023) begin
      run_cycle(3'd5, '0, 1'b1, en);
      exp_ctr++;
    end
    run_cycle(3'd5, '0, 1'b1, en);
    chk(last_row == 10'd1023, "R7 top row", last_row, 1023);
    run_cycle(3'd5, '0, 1'b1, en);
    chk(last_row == 10'd0, "R7 wrap to 0", last_row, 0);
    run_cycle(3'd5, '0, 1'b1, en);
    chk(last_row == 10'd1, "R7 step after wrap", last_row, 1);

    // R7: reset clears the counter
    rst = 1; wt(2); rst = 0; wt(2);
    run_cycle(3'd5, '0, 1'b1, en);
    chk(last_row == 10'd0, "R7 counter 0 after reset", last_row, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule